// File: doc/BRIEF.md
# Driven-Pattern Tri-State Pin Classifier

This block tells whether an external input pin is being driven low, driven high, or left floating. It puts a known stimulus on a separate output pin, `stim_o`. On the board, that pin reaches the sensed input through a series resistor of roughly 10 kilohms. A floating input is pulled by the resistor and follows the stimulus. A source that overpowers the resistor holds the input at its own level.

The stimulus is either a square wave or a pseudo-random bit sequence. The input goes through a synchronizer. It is compared, once per stimulus bit, with a copy of the stimulus delayed by the same number of cycles. At the end of each observation window the block reports one of three classes and raises a one-cycle valid strobe. It then starts the next window by itself.

The default timing suits a 50 MHz clock. A stimulus bit is 25 cycles long, which gives a 1 MHz square wave.

Top module: `pin_state_classifier`

## Requirements
- R1: While rst_ni is low and on the first cycle after it, class_o is 2'b11 (no result yet), valid_o is 0 and stim_o is 0.
- R2: The stimulus advances in bits of exactly CLK_DIV clock cycles, and stim_o changes only on a bit boundary.
- R3: With mode_i = 0 (square mode), stim_o inverts at every bit boundary.
- R4: With mode_i = 1 (random mode), stim_o follows the top bit of a 7-bit maximal LFSR with feedback polynomial x^7+x^6+1. The register is never all-zero, so any 127 consecutive bits contain exactly 64 ones.
- R5: The input is sampled once per stimulus bit, in the bit's last cycle, after a 2-flop synchronizer. It is compared with the stimulus delayed by the same 2 cycles. A window is WIN_BITS such samples.
- R6: If every sample in a window equals the delayed stimulus, class_o becomes 2'b10 (floating). This holds in either mode.
- R7: An input held at 0 for a whole window gives class_o = 2'b00. An input held at 1 gives 2'b01. This holds in either mode.
- R8: A window with at least one mismatch is classified by majority. It is 2'b01 if more than half of its samples are 1, and 2'b00 otherwise, so a tie gives 2'b00.
- R9: valid_o is a one-cycle pulse once every WIN_BITS*CLK_DIV cycles. class_o changes only together with valid_o, and windows follow one another without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Stimulus select: 0 square wave, 1 pseudo-random |
| sense_i | input | 1 | Asynchronous pin under test |
| stim_o | output | 1 | Stimulus driven toward the pin through a resistor |
| class_o | output | 2 | 00 low, 01 high, 10 floating, 11 no result yet |
| valid_o | output | 1 | One-cycle strobe when class_o is updated |

## Verification
The pin is modelled in several ways:
- Tied low or tied high, in both stimulus modes. This separates a driven pin from a floating one, whatever the pattern is.
- Wired straight to `stim_o`, in both modes. This models the floating case, where a full match must win over the majority rule.
- Driven to the inverse of a square stimulus. Every sample mismatches and the ones make up exactly half, which exercises the tie rule.
- Following the stimulus on high bits but only on every other low bit. This gives a three-quarter majority with mismatches present.

The stimulus itself is checked for its bit length, for toggling in square mode, and for the ones count of a maximal sequence in random mode.

// File: rtl/pin_cls_pkg.sv
package pin_cls_pkg;
  typedef enum logic [1:0] {
    CLS_LOW   = 2'b00,
    CLS_HIGH  = 2'b01,
    CLS_FLOAT = 2'b10,
    CLS_NONE  = 2'b11
  } pin_cls_e;

  localparam int unsigned LFSR_W = 7;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 7'h01;
endpackage

// File: rtl/bit_delay.sv
module bit_delay #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/stim_gen.sv
module stim_gen
  import pin_cls_pkg::*;
#(
  parameter int unsigned CLK_DIV = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  output logic tick_o,
  output logic stim_o
);
  localparam int unsigned DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0]     div_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic              stim_q;

  assign tick_o = (div_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;

  // x^7 + x^6 + 1, runs in both modes
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     lfsr_q <= LFSR_SEED;
    else if (tick_o) lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[6] ^ lfsr_q[5]};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     stim_q <= 1'b0;
    else if (tick_o) stim_q <= mode_i ? lfsr_q[LFSR_W-1] : ~stim_q;

  assign stim_o = stim_q;

  p_stim_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(stim_o));
  p_square_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !mode_i) |=> (stim_o != $past(stim_o)));
  p_lfsr_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

// File: rtl/win_eval.sv
module win_eval
  import pin_cls_pkg::*;
#(
  parameter int unsigned WIN_BITS = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       sense_i,
  input  logic       ref_i,
  output logic [1:0] class_o,
  output logic       valid_o
);
  localparam int unsigned BW = $clog2(WIN_BITS);
  localparam int unsigned CW = $clog2(WIN_BITS + 1);

  logic [BW-1:0] bit_q;
  logic [CW-1:0] ones_q;
  logic          mis_q;
  pin_cls_e      class_q;
  logic          valid_q;

  logic          last;
  logic [CW-1:0] ones_tot;
  logic          mis_tot;
  logic [CW:0]   ones_dbl;
  pin_cls_e      verdict;

  always_comb begin
    last     = (bit_q == BW'(WIN_BITS - 1));
    ones_tot = ones_q + CW'(sense_i);
    mis_tot  = mis_q | (sense_i != ref_i);
    ones_dbl = {ones_tot, 1'b0};
    if (!mis_tot)                           verdict = CLS_FLOAT;
    else if (ones_dbl > (CW+1)'(WIN_BITS))  verdict = CLS_HIGH;
    else                                    verdict = CLS_LOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bit_q   <= '0;
      ones_q  <= '0;
      mis_q   <= 1'b0;
      class_q <= CLS_NONE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick_i) begin
        if (last) begin
          bit_q   <= '0;
          ones_q  <= '0;
          mis_q   <= 1'b0;
          class_q <= verdict;
          valid_q <= 1'b1;
        end else begin
          bit_q  <= bit_q + 1'b1;
          ones_q <= ones_tot;
          mis_q  <= mis_tot;
        end
      end
    end

  assign class_o = class_q;
  assign valid_o = valid_q;

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_class_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(class_o) |-> valid_o);
  p_valid_at_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));
  p_match_float_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && last && !mis_tot) |=> (class_o == CLS_FLOAT));
endmodule

// File: rtl/pin_state_classifier.sv
module pin_state_classifier #(
  parameter int unsigned CLK_DIV     = 25,
  parameter int unsigned WIN_BITS    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_i,
  input  logic       sense_i,
  output logic       stim_o,
  output logic [1:0] class_o,
  output logic       valid_o
);
  logic tick;
  logic stim;
  logic sense_sync;
  logic stim_dly;

  stim_gen #(.CLK_DIV(CLK_DIV)) u_stim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .tick_o (tick),
    .stim_o (stim)
  );

  bit_delay #(.STAGES(SYNC_STAGES)) u_sense_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sense_i),
    .q_o    (sense_sync)
  );

  // reference aligned to the synchronizer latency
  bit_delay #(.STAGES(SYNC_STAGES)) u_stim_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (stim),
    .q_o    (stim_dly)
  );

  win_eval #(.WIN_BITS(WIN_BITS)) u_eval (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .sense_i (sense_sync),
    .ref_i   (stim_dly),
    .class_o (class_o),
    .valid_o (valid_o)
  );

  assign stim_o = stim;
endmodule

// File: tb/pin_state_classifier_tb.sv
module pin_state_classifier_tb_top;
  localparam int unsigned CLK_DIV  = 8;
  localparam int unsigned WIN_BITS = 16;
  localparam int unsigned WIN_CYC  = CLK_DIV * WIN_BITS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic       sense;
  logic       stim;
  logic [1:0] cls;
  logic       valid;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned drv = 0;
  logic        alt = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  always @(negedge stim) alt <= ~alt;

  always_comb begin
    case (drv)
      0:       sense = 1'b0;
      1:       sense = 1'b1;
      2:       sense = stim;
      3:       sense = ~stim;
      default: sense = stim | alt;
    endcase
  end

  pin_state_classifier #(.CLK_DIV(CLK_DIV), .WIN_BITS(WIN_BITS), .SYNC_STAGES(2)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .mode_i  (mode),
    .sense_i (sense),
    .stim_o  (stim),
    .class_o (cls),
    .valid_o (valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_valid(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!valid && gap < 4 * WIN_CYC);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(cls == 2'b11, "R1 class", cls, 3);
    check(valid == 1'b0, "R1 valid", valid, 0);
    check(stim == 1'b0, "R1 stim", stim, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cls == 2'b11 && !valid && !stim, "R1 first cycle", {cls, valid, stim}, 12);
  endtask

  task automatic t_square_stim;
    int gap;
    logic s0;
    bit hold_ok = 1'b1, tog_ok = 1'b1;
    mode = 1'b0;
    wait_valid(gap);
    wait_valid(gap);
    for (int b = 0; b < 8; b++) begin
      s0 = stim;
      repeat (CLK_DIV - 1) begin
        @(negedge clk);
        if (stim != s0) hold_ok = 1'b0;
      end
      @(negedge clk);
      if (stim == s0) tog_ok = 1'b0;
    end
    check(hold_ok, "R2 bit hold", hold_ok, 1);
    check(tog_ok, "R3 square toggle", tog_ok, 1);
  endtask

  task automatic t_prbs_stim;
    int gap;
    int ones = 0;
    mode = 1'b1;
    wait_valid(gap);
    for (int b = 0; b < 127; b++) begin
      ones += int'(stim);
      repeat (CLK_DIV) @(negedge clk);
    end
    check(ones == 64, "R4 prbs ones in 127 bits", ones, 64);
  endtask

  task automatic t_class(input logic m, input int d, input logic [1:0] exp, input string req);
    int gap;
    mode = m;
    drv  = d;
    wait_valid(gap);
    wait_valid(gap);
    check(valid && cls == exp, req, cls, exp);
    wait_valid(gap);
    check(valid && cls == exp, req, cls, exp);
  endtask

  task automatic t_timing;
    int gap;
    logic [1:0] c0;
    bit held = 1'b1;
    mode = 1'b0;
    drv  = 1;
    wait_valid(gap);
    wait_valid(gap);
    check(gap == WIN_CYC, "R9 window period", gap, WIN_CYC);
    @(negedge clk);
    check(!valid, "R9 one-cycle pulse", valid, 0);
    c0 = cls;
    drv = 0;
    for (int i = 0; i < int'(WIN_CYC) - 2; i++) begin
      @(negedge clk);
      if (!valid && cls != c0) held = 1'b0;
      if (valid) break;
    end
    check(held, "R9 class held between strobes", held, 1);
    wait_valid(gap);
    check(gap <= WIN_CYC && valid, "R9 continuous restart", gap, WIN_CYC);
  endtask

  initial begin
    t_reset();
    t_square_stim();
    t_prbs_stim();
    t_class(1'b0, 0, 2'b00, "R7 square low");
    t_class(1'b0, 1, 2'b01, "R7 square high");
    t_class(1'b1, 0, 2'b00, "R7 prbs low");
    t_class(1'b1, 1, 2'b01, "R7 prbs high");
    t_class(1'b0, 2, 2'b10, "R6 square float");
    t_class(1'b1, 2, 2'b10, "R6 prbs float");
    t_class(1'b0, 3, 2'b00, "R8 tie to low R5");
    t_class(1'b0, 4, 2'b01, "R8 majority high");
    t_timing();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule